// File: doc/BRIEF.md
# Boot Mode Select Sequencer

This block runs once after reset. It waits for the on-chip self-test to finish and then for the root clock PLL to lock. At that point it captures three sense-on-power strap pins, and the captured value decides the boot path. The path can be a normal boot from external serial flash, a service loop for a host programmer, a debug hold with the processor halted, or a sticky error for any code that has no defined meaning.

A normal boot starts with a discovery query to a separate flash-read engine. If the query gets a valid answer, the sequencer asks the engine to load image slots one after another at fixed offsets spaced 512 KiB apart. It stops at the first slot that loads without corruption. If every slot is corrupt, it reports a boot failure and stops there. If the discovery query gets an invalid answer, the sequencer takes the SPI path instead. It raises a host interrupt to signal that it is ready, then waits for the host to finish a download. Either successful path maps RAM over the boot ROM for one cycle before it releases the CPU. The block also produces a flash serial clock enable at one fifth of the system clock.

Top module: `boot_seq_top`

## Requirements
- R1: After reset, status is 0 (busy), mode is 0 and cpuRelease, eclipse, hostIrq and flReq are low. No flash request is made until bistDone and then pllLock have been seen.
- R2: The strap pins are captured in the cycle pllLock is first seen high. Strap changes before or after that cycle have no effect on the chosen path.
- R3: Strap code 3'b001 (bit 2 first) selects functional mode (mode 1). The first flash request in this mode is a discovery query with flOp=0.
- R4: After a valid query, loads (flOp=1) go to flAddr 0x000000, 0x080000, 0x100000 and 0x180000 in that order. The next slot is tried only after the current load returns flOk=0. The first load that returns flOk=1 gives status 1.
- R5: If all four loads fail, status becomes 6. No further requests are made and the CPU is never released.
- R6: If the query returns flOk=0, no load is requested. hostIrq stays high until spiLoadDone, after which status becomes 2 and the CPU is released.
- R7: eclipse rises exactly one cycle before cpuRelease, and both then stay high.
- R8: Strap 3'b101 gives mode 2 and status 3. No flash request is made and the CPU is not released.
- R9: Strap 3'b011 gives mode 3 and status 4. No flash request is made and the CPU is not released.
- R10: Any other strap code gives mode 0 and status 5. This status holds until reset.
- R11: flClkEn is high for one cycle in every 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| strapIn | input | 3 | Sense-on-power strap pins, bit 2 first |
| bistDone | input | 1 | Self-test phase finished |
| pllLock | input | 1 | Root PLL locked |
| flReq | output | 1 | One-cycle request to the flash-read engine |
| flOp | output | 1 | 0 = discovery query, 1 = slot load |
| flAddr | output | 24 | Flash offset of the requested slot |
| flDone | input | 1 | Flash engine finished the request |
| flOk | input | 1 | Request result: 1 valid/clean, 0 invalid/corrupt |
| hostIrq | output | 1 | Host interrupt, ready for an SPI download |
| spiLoadDone | input | 1 | Host download over SPI complete |
| flClkEn | output | 1 | Flash serial clock enable, sysclk/5 |
| bootMode | output | 2 | 0 none/invalid, 1 functional, 2 flashing, 3 debug |
| bootStatus | output | 3 | 0 busy, 1 flash boot, 2 SPI boot, 3 service, 4 debug, 5 strap error, 6 all slots bad |
| eclipse | output | 1 | RAM mapped over the boot ROM |
| cpuRelease | output | 1 | Processor released from reset |

## Verification
The strap codes are run through all three defined modes and two undefined ones, which separates the mode decode from the error default. Functional boots use slot-failure masks that succeed at slot 0, slot 1 (after one failure, and also with a later slot marked bad), slot 3 and never, plus one run with an invalid query. Together these show whether the sequencer walks the offsets in order and stops at the first good slot, and whether it goes to SPI only when the query fails. Directed runs change the straps just before and just after PLL lock, to show exactly when they are sampled.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [3:0] {
    ST_BIST, ST_PLL, ST_DECODE, ST_PROBE_REQ, ST_PROBE_WAIT,
    ST_LOAD_REQ, ST_LOAD_WAIT, ST_SPI_WAIT, ST_ECLIPSE, ST_RUN,
    ST_SERVICE, ST_DEBUG, ST_STRAP_ERR, ST_ALL_BAD
  } seqState_e;

  typedef struct packed {
    logic captureStrap;
    logic slotClear;
    logic slotAdvance;
  } dpCtl_t;

  localparam logic [2:0] STRAP_FUNC  = 3'b001;
  localparam logic [2:0] STRAP_FLASH = 3'b101;
  localparam logic [2:0] STRAP_DEBUG = 3'b011;

  localparam logic [1:0] MODE_NONE  = 2'd0;
  localparam logic [1:0] MODE_FUNC  = 2'd1;
  localparam logic [1:0] MODE_FLASH = 2'd2;
  localparam logic [1:0] MODE_DEBUG = 2'd3;

  localparam logic [2:0] STAT_BUSY     = 3'd0;
  localparam logic [2:0] STAT_FLASH_OK = 3'd1;
  localparam logic [2:0] STAT_SPI_OK   = 3'd2;
  localparam logic [2:0] STAT_SERVICE  = 3'd3;
  localparam logic [2:0] STAT_DEBUG    = 3'd4;
  localparam logic [2:0] STAT_STRAPERR = 3'd5;
  localparam logic [2:0] STAT_ALLBAD   = 3'd6;
endpackage

// File: rtl/boot_seq_dp.sv
module boot_seq_dp
  import boot_seq_pkg::*;
#(
  parameter int SLOT_COUNT = 4,
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] SLOT_STRIDE = 24'h080000,
  parameter int CLK_DIV = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [2:0]        strapIn,
  output logic [2:0]        strapCode,
  output logic              slotLast,
  output logic [ADDR_W-1:0] flAddr,
  output logic [1:0]        bootMode,
  output logic              flClkEn
);
  localparam int SLOT_W = (SLOT_COUNT > 1) ? $clog2(SLOT_COUNT) : 1;
  localparam int DIV_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [SLOT_W-1:0] slotIdx;
  logic [DIV_W-1:0]  divCnt;
  logic [2:0]        strapReg;
  logic [1:0]        modeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapReg <= '0;
      modeReg  <= MODE_NONE;
    end else if (ctl.captureStrap) begin
      strapReg <= strapIn;
      case (strapIn)
        STRAP_FUNC:  modeReg <= MODE_FUNC;
        STRAP_FLASH: modeReg <= MODE_FLASH;
        STRAP_DEBUG: modeReg <= MODE_DEBUG;
        default:     modeReg <= MODE_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                slotIdx <= '0;
    else if (ctl.slotClear)   slotIdx <= '0;
    else if (ctl.slotAdvance) slotIdx <= slotIdx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              divCnt <= '0;
    else if (divCnt == DIV_W'(CLK_DIV - 1)) divCnt <= '0;
    else                                    divCnt <= divCnt + 1'b1;
  end

  assign strapCode = strapReg;
  assign bootMode  = modeReg;
  assign slotLast  = (slotIdx == SLOT_W'(SLOT_COUNT - 1));
  assign flAddr    = ADDR_W'(slotIdx) * SLOT_STRIDE;
  assign flClkEn   = (divCnt == DIV_W'(CLK_DIV - 1));

  // R4
  slot_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.slotAdvance |-> !slotLast);
  // R11
  clk_en_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    flClkEn |=> !flClkEn);
  // R2
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.captureStrap |=> $stable(strapCode));
endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bistDone,
  input  logic       pllLock,
  input  logic [2:0] strapCode,
  input  logic       slotLast,
  input  logic       flDone,
  input  logic       flOk,
  input  logic       spiLoadDone,
  output dpCtl_t     ctl,
  output logic       flReq,
  output logic       flOp,
  output logic       hostIrq,
  output logic       eclipse,
  output logic       cpuRelease,
  output logic [2:0] bootStatus
);
  seqState_e state, nextState;
  logic viaSpi;

  always_comb begin
    nextState = state;
    ctl = '0;
    case (state)
      ST_BIST: if (bistDone) nextState = ST_PLL;
      ST_PLL: if (pllLock) begin
        ctl.captureStrap = 1'b1;
        nextState = ST_DECODE;
      end
      ST_DECODE: begin
        ctl.slotClear = 1'b1;
        case (strapCode)
          STRAP_FUNC:  nextState = ST_PROBE_REQ;
          STRAP_FLASH: nextState = ST_SERVICE;
          STRAP_DEBUG: nextState = ST_DEBUG;
          default:     nextState = ST_STRAP_ERR;
        endcase
      end
      ST_PROBE_REQ: nextState = ST_PROBE_WAIT;
      ST_PROBE_WAIT: if (flDone) nextState = flOk ? ST_LOAD_REQ : ST_SPI_WAIT;
      ST_LOAD_REQ: nextState = ST_LOAD_WAIT;
      ST_LOAD_WAIT: if (flDone) begin
        if (flOk) nextState = ST_ECLIPSE;
        else if (slotLast) nextState = ST_ALL_BAD;
        else begin
          ctl.slotAdvance = 1'b1;
          nextState = ST_LOAD_REQ;
        end
      end
      ST_SPI_WAIT: if (spiLoadDone) nextState = ST_ECLIPSE;
      ST_ECLIPSE: nextState = ST_RUN;
      default: nextState = state;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_BIST;
      viaSpi <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_PROBE_WAIT && flDone && !flOk) viaSpi <= 1'b1;
    end
  end

  assign flReq      = (state == ST_PROBE_REQ) || (state == ST_LOAD_REQ);
  assign flOp       = (state == ST_LOAD_REQ);
  assign hostIrq    = (state == ST_SPI_WAIT);
  assign eclipse    = (state == ST_ECLIPSE) || (state == ST_RUN);
  assign cpuRelease = (state == ST_RUN);

  always_comb begin
    case (state)
      ST_RUN:       bootStatus = viaSpi ? STAT_SPI_OK : STAT_FLASH_OK;
      ST_SERVICE:   bootStatus = STAT_SERVICE;
      ST_DEBUG:     bootStatus = STAT_DEBUG;
      ST_STRAP_ERR: bootStatus = STAT_STRAPERR;
      ST_ALL_BAD:   bootStatus = STAT_ALLBAD;
      default:      bootStatus = STAT_BUSY;
    endcase
  end

  // R7
  eclipse_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuRelease) |-> $past(eclipse));
  // R7
  release_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuRelease |=> cpuRelease && eclipse);
  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    flReq |=> !flReq);
  // R6
  irq_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |-> !flReq);
  // R10
  strap_err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bootStatus == STAT_STRAPERR) |=> (bootStatus == STAT_STRAPERR));
  // R5
  all_bad_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bootStatus == STAT_ALLBAD) |-> !flReq && !cpuRelease);
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int SLOT_COUNT = 4,
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] SLOT_STRIDE = 24'h080000,
  parameter int CLK_DIV = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        strapIn,
  input  logic              bistDone,
  input  logic              pllLock,
  output logic              flReq,
  output logic              flOp,
  output logic [ADDR_W-1:0] flAddr,
  input  logic              flDone,
  input  logic              flOk,
  output logic              hostIrq,
  input  logic              spiLoadDone,
  output logic              flClkEn,
  output logic [1:0]        bootMode,
  output logic [2:0]        bootStatus,
  output logic              eclipse,
  output logic              cpuRelease
);
  dpCtl_t     ctl;
  logic [2:0] strapCode;
  logic       slotLast;

  boot_seq_ctrl i_ctrl (
    .clk, .rstN, .bistDone, .pllLock, .strapCode, .slotLast,
    .flDone, .flOk, .spiLoadDone, .ctl, .flReq, .flOp, .hostIrq,
    .eclipse, .cpuRelease, .bootStatus
  );

  boot_seq_dp #(
    .SLOT_COUNT(SLOT_COUNT), .ADDR_W(ADDR_W),
    .SLOT_STRIDE(SLOT_STRIDE), .CLK_DIV(CLK_DIV)
  ) i_dp (
    .clk, .rstN, .ctl, .strapIn, .strapCode, .slotLast, .flAddr,
    .bootMode, .flClkEn
  );
endmodule

// File: tb/test_boot_seq_top.sv
module test_boot_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {strap[16:14], probeOk[13], failMask[12:9], status[8:6], mode[5:4], release[3], loads[2:0]}
  localparam logic [16:0] VEC [NVEC] = '{
    {3'b001, 1'b1, 4'b0000, 3'd1, 2'd1, 1'b1, 3'd1},
    {3'b001, 1'b1, 4'b0001, 3'd1, 2'd1, 1'b1, 3'd2},
    {3'b001, 1'b1, 4'b0101, 3'd1, 2'd1, 1'b1, 3'd2},
    {3'b001, 1'b1, 4'b0111, 3'd1, 2'd1, 1'b1, 3'd4},
    {3'b001, 1'b1, 4'b1111, 3'd6, 2'd1, 1'b0, 3'd4},
    {3'b001, 1'b0, 4'b0000, 3'd2, 2'd1, 1'b1, 3'd0},
    {3'b101, 1'b1, 4'b0000, 3'd3, 2'd2, 1'b0, 3'd0},
    {3'b011, 1'b1, 4'b0000, 3'd4, 2'd3, 1'b0, 3'd0},
    {3'b000, 1'b1, 4'b0000, 3'd5, 2'd0, 1'b0, 3'd0},
    {3'b111, 1'b1, 4'b0000, 3'd5, 2'd0, 1'b0, 3'd0}
  };

  logic clk = 0, rstN = 0;
  logic [2:0] strapIn = 3'b000;
  logic bistDone = 0, pllLock = 0, flDone = 0, flOk = 0, spiLoadDone = 0;
  logic flReq, flOp, hostIrq, flClkEn, eclipse, cpuRelease;
  logic [23:0] flAddr;
  logic [1:0] bootMode;
  logic [2:0] bootStatus;

  int checks = 0, errors = 0, cycles = 0;
  int reqs = 0, probes = 0, loads = 0, addrErr = 0, cnt = 0;
  bit busy = 0, firstProbe = 0, irqSeen = 0, orderErr = 0, prevEcl = 0;
  bit probeOk = 1;
  logic [3:0] failMask = '0;
  logic curOp;
  logic [1:0] curSlot;

  boot_seq_top i_boot_seq_top (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // flash engine model and monitors, evaluated away from the active edge
  always @(negedge clk) begin
    flDone = 0;
    if (!rstN) begin
      busy = 0; reqs = 0; probes = 0; loads = 0; addrErr = 0;
      firstProbe = 0; irqSeen = 0; orderErr = 0; prevEcl = 0;
    end else begin
      if (hostIrq) irqSeen = 1;
      if (cpuRelease && !prevEcl) orderErr = 1;
      prevEcl = eclipse;
      if (busy) begin
        cnt--;
        if (cnt == 0) begin
          flDone = 1;
          flOk = curOp ? !failMask[curSlot] : probeOk;
          busy = 0;
        end
      end else if (flReq) begin
        if (reqs == 0 && !flOp) firstProbe = 1;
        reqs++;
        if (flOp) begin
          if (flAddr != 24'(loads) * 24'h080000) addrErr++;
          loads++;
        end else probes++;
        curOp = flOp; curSlot = flAddr[20:19];
        busy = 1; cnt = 2;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic boot(input logic [2:0] s);
    rstN = 0; bistDone = 0; pllLock = 0; spiLoadDone = 0; strapIn = s;
    cyc(3); rstN = 1; cyc(4);
    bistDone = 1; cyc(2); pllLock = 1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state and wait for self-test and lock
    cyc(2);
    check(bootStatus == 0 && bootMode == 0 && !cpuRelease && !eclipse && !hostIrq && !flReq,
          "R1 reset", bootStatus, 0);
    strapIn = 3'b001; rstN = 1; cyc(10);
    check(reqs == 0 && bootStatus == 0, "R1 no request before bist", reqs, 0);
    bistDone = 1; cyc(10);
    check(reqs == 0 && bootStatus == 0, "R1 no request before lock", reqs, 0);

    // table walk: R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      probeOk = VEC[i][13]; failMask = VEC[i][12:9];
      boot(VEC[i][16:14]);
      cyc(40);
      if (VEC[i][16:14] == 3'b001 && !VEC[i][13]) begin
        check(irqSeen && hostIrq && !cpuRelease && loads == 0, "R6 irq before download", int'(hostIrq), 1);
        spiLoadDone = 1; cyc(1); spiLoadDone = 0; cyc(10);
        check(!hostIrq, "R6 irq drops", int'(hostIrq), 0);
      end else begin
        check(!irqSeen, "R6 no irq on flash path", int'(irqSeen), 0);
      end
      check(bootStatus == VEC[i][8:6], $sformatf("R4/R5/R8/R9/R10 status vec%0d", i), bootStatus, VEC[i][8:6]);
      check(bootMode == VEC[i][5:4], $sformatf("R3/R8/R9 mode vec%0d", i), bootMode, VEC[i][5:4]);
      check(cpuRelease == VEC[i][3], $sformatf("R5/R8/R9 release vec%0d", i), cpuRelease, VEC[i][3]);
      check(loads == VEC[i][2:0] && addrErr == 0, $sformatf("R4 slot order vec%0d", i), loads, VEC[i][2:0]);
      if (VEC[i][16:14] == 3'b001)
        check(firstProbe && probes == 1, "R3 query first", probes, 1);
      else
        check(reqs == 0, "R8/R9/R10 no flash request", reqs, 0);
      if (VEC[i][3])
        check(!orderErr && eclipse, "R7 eclipse before release", int'(orderErr), 0);
      pllLock = 0; cyc(5);
      check(bootStatus == VEC[i][8:6] && reqs == VEC[i][2:0] + (VEC[i][16:14] == 3'b001 ? 1 : 0),
            "R5/R10 state holds", bootStatus, VEC[i][8:6]);
    end

    // R2 strap changed before lock: value at lock wins
    probeOk = 1; failMask = 0;
    rstN = 0; bistDone = 0; pllLock = 0; strapIn = 3'b101; cyc(3);
    rstN = 1; bistDone = 1; cyc(3); strapIn = 3'b001; cyc(1); pllLock = 1; cyc(30);
    check(bootMode == 1 && bootStatus == 1, "R2 sampled at lock", bootMode, 1);
    // R2 strap changed after lock: ignored
    boot(3'b011); cyc(1); strapIn = 3'b001; cyc(30);
    check(bootMode == 3 && bootStatus == 4 && reqs == 0, "R2 change after lock ignored", bootMode, 3);

    // R11 clock enable every 5 cycles
    begin
      int ones = 0, gapErr = 0, last = -1;
      for (int k = 0; k < 50; k++) begin
        if (flClkEn) begin
          if (last >= 0 && k - last != 5) gapErr++;
          last = k; ones++;
        end
        cyc(1);
      end
      check(ones == 10 && gapErr == 0, "R11 divide by 5", ones, 10);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule